// File: doc/BRIEF.md
# Interlocked Strobe/Acknowledge Word Link

This block moves data words from a local producer to a local consumer over a fully interlocked four-phase handshake. A sender end takes words from a valid/ready input, holds each one on a link data bus and raises a strobe. A receiver end answers the strobe with an acknowledge and hands the word to its consumer on a one-cycle valid output. No new strobe starts until the acknowledge from the previous word has gone high and then low again. Because of this, one word needs at least two clock cycles, and the link never runs faster than half the clock rate.

Both ends run on the same clock. The receiver has two build variants, chosen by a parameter. In the fast variant the acknowledge follows the strobe within the same cycle, which gives the peak rate of one word every two clocks. In the registered variant the acknowledge comes from a flop, which removes every combinational path between the two ends and costs four clocks per word. The strobe, acknowledge and link data are brought out at the ports so that the handshake can be watched from outside.

Top module: `strobe_ack_link`

## Requirements
- R1: While reset is asserted and right after it is released, link_strobe, link_ack and out_valid are 0 and in_ready is 1.
- R2: in_ready is 0 whenever link_strobe or link_ack is 1, and a word is taken only in a cycle where in_valid and in_ready are both 1.
- R3: link_data does not change while link_strobe stays high, so in_data changes made while the link is busy have no effect on the word in flight.
- R4: link_ack rises only in a cycle where link_strobe is high, and it falls only in a cycle where link_strobe is low.
- R5: The sender drops link_strobe in the cycle after it samples link_strobe and link_ack both high.
- R6: Every accepted word is delivered exactly once: out_valid pulses high for exactly one cycle, one cycle after the word is accepted, with out_data equal to that word.
- R7: Words are delivered in the order they were accepted.
- R8: With in_valid held high, one word is accepted and delivered every 2 cycles when ACK_REGISTERED is 0 and every 4 cycles when ACK_REGISTERED is 1, never faster than one word every 2 cycles.
- R9: Reset applied while a transfer is in progress forces link_strobe and link_ack low and discards the word: no out_valid pulse appears for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ends |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Sender can take a word this cycle |
| in_data | input | DATA_W | Word offered by the producer |
| out_valid | output | 1 | One-cycle pulse: a word is delivered |
| out_data | output | DATA_W | Delivered word, valid with out_valid |
| link_strobe | output | 1 | Handshake strobe from sender to receiver |
| link_ack | output | 1 | Handshake acknowledge from receiver to sender |
| link_data | output | DATA_W | Word held on the link by the sender |

## Verification
The hardest situation to reach is a reset that lands after a word has been accepted but before the receiver delivers it, since the window is one or a few cycles wide and depends on the variant. The bench reaches it by offering one word from an idle link and asserting reset on the very next cycle, then checks that no delivery follows. The back-to-back case, where the sender takes the next word in the same cycle it sees the acknowledge fall, is reached by holding in_valid high for a long stream while in_data changes every cycle, with both variants driven by the same stimulus.

// File: rtl/sal_pkg.sv
package sal_pkg;

   // Phases of the sending end of the link.
   typedef enum logic [1:0] {
      TX_IDLE    = 2'd0,   // no transfer, acknowledge low
      TX_STROBE  = 2'd1,   // strobe high, waiting for acknowledge
      TX_RELEASE = 2'd2    // strobe dropped, waiting for acknowledge to fall
   } tx_phase_e;

   // Cycles per word for each receiver variant.
   function automatic int unsigned word_period(input int unsigned ack_registered);
      return (ack_registered != 0) ? 4 : 2;
   endfunction

endpackage

// File: rtl/sal_sender.sv
module sal_sender
   import sal_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              strobe,
   input  logic              ack,
   output logic [DATA_W-1:0] link_data
);

   tx_phase_e         phase_q, phase_d;
   logic [DATA_W-1:0] word_q;
   logic              take;

   // A new word may be taken from idle, or as soon as the previous
   // acknowledge is seen low after the strobe has been released.
   assign in_ready = (phase_q == TX_IDLE) ||
                     ((phase_q == TX_RELEASE) && !ack);
   assign take     = in_valid && in_ready;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         TX_IDLE: begin
            if (take) phase_d = TX_STROBE;
         end
         TX_STROBE: begin
            if (ack) phase_d = TX_RELEASE;
         end
         TX_RELEASE: begin
            if (take)      phase_d = TX_STROBE;
            else if (!ack) phase_d = TX_IDLE;
         end
         default: phase_d = TX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= TX_IDLE;
         word_q  <= '0;
      end else begin
         phase_q <= phase_d;
         if (take) word_q <= in_data;
      end
   end

   assign strobe    = (phase_q == TX_STROBE);
   assign link_data = word_q;

   // R2
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe || ack) |-> !in_ready);

   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && $past(strobe)) |-> $stable(link_data));

   // R5
   strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && ack) |=> !strobe);

endmodule

// File: rtl/sal_receiver.sv
module sal_receiver #(
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned ACK_REGISTERED = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [DATA_W-1:0] link_data,
   output logic              ack,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   logic              strobe_d;
   logic              first_seen;
   logic [DATA_W-1:0] hold_q;
   logic              pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_d <= 1'b0;
      else        strobe_d <= strobe;
   end

   generate
      if (ACK_REGISTERED != 0) begin : g_ack_flop
         // Acknowledge one cycle behind the strobe: no path between ends.
         assign ack = strobe_d;
      end else begin : g_ack_direct
         // Acknowledge follows the strobe in the same cycle: peak rate.
         assign ack = strobe;
      end
   endgenerate

   // The first cycle of each strobe carries a new word.
   assign first_seen = strobe && !strobe_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         hold_q  <= '0;
      end else begin
         pulse_q <= first_seen;
         if (first_seen) hold_q <= link_data;
      end
   end

   assign out_valid = pulse_q;
   assign out_data  = hold_q;

   // R4
   ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> strobe);

   // R4
   ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> !strobe);

   // R6
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

endmodule

// File: rtl/strobe_ack_link.sv
module strobe_ack_link
   import sal_pkg::*;
#(
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned ACK_REGISTERED = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              link_strobe,
   output logic              link_ack,
   output logic [DATA_W-1:0] link_data
);

   localparam int unsigned PERIOD = word_period(ACK_REGISTERED);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("strobe_ack_link: DATA_W must be at least 1");
      end
      if (ACK_REGISTERED > 1) begin : g_bad_variant
         $error("strobe_ack_link: ACK_REGISTERED must be 0 or 1");
      end
      if (PERIOD < 2) begin : g_bad_period
         $error("strobe_ack_link: a word cannot take fewer than two cycles");
      end
   endgenerate

   logic              strobe_w;
   logic              ack_w;
   logic [DATA_W-1:0] data_w;

   sal_sender #(
      .DATA_W (DATA_W)
   ) u_sender (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .strobe    (strobe_w),
      .ack       (ack_w),
      .link_data (data_w)
   );

   sal_receiver #(
      .DATA_W         (DATA_W),
      .ACK_REGISTERED (ACK_REGISTERED)
   ) u_receiver (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (strobe_w),
      .link_data (data_w),
      .ack       (ack_w),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   assign link_strobe = strobe_w;
   assign link_ack    = ack_w;
   assign link_data   = data_w;

endmodule

// File: tb/test_strobe_ack_link.sv
module test_strobe_ack_link;

   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [W-1:0] in_data = '0;

   logic [1:0]   rdy, ov, stb, ack;
   logic [W-1:0] od [2];
   logic [W-1:0] ld [2];

   always #2 clk = ~clk;   // 250 MHz

   strobe_ack_link #(.DATA_W(W), .ACK_REGISTERED(0)) i_strobe_ack_link (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]),
      .in_data(in_data), .out_valid(ov[0]), .out_data(od[0]),
      .link_strobe(stb[0]), .link_ack(ack[0]), .link_data(ld[0]));

   strobe_ack_link #(.DATA_W(W), .ACK_REGISTERED(1)) i_strobe_ack_link_reg (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]),
      .in_data(in_data), .out_valid(ov[1]), .out_data(od[1]),
      .link_strobe(stb[1]), .link_ack(ack[1]), .link_data(ld[1]));

   int checks = 0;
   int failures = 0;

   // Behavioural model, one set per instance.
   int           period [2] = '{2, 4};
   int           busy   [2];
   bit           pend   [2];
   bit           expv   [2];
   logic [W-1:0] pdata  [2];
   logic [W-1:0] expd   [2];
   logic [W-1:0] order_q [2][$];
   int           sent   [2];
   int           got    [2];
   int           window [2];
   bit           pstb   [2];
   bit           pack   [2];
   logic [W-1:0] pld    [2];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_all();
      for (int k = 0; k < 2; k++) begin
         chk(rdy[k] == (busy[k] == 0), "R2 in_ready", rdy[k], busy[k] == 0);
         chk(ov[k] == expv[k], "R6 out_valid timing", ov[k], expv[k]);
         if (ov[k]) begin
            got[k]++;
            window[k]++;
            chk(od[k] == expd[k], "R6 out_data", od[k], expd[k]);
            if (order_q[k].size() > 0) begin
               chk(od[k] == order_q[k][0], "R7 order", od[k], order_q[k][0]);
               void'(order_q[k].pop_front());
            end else begin
               chk(1'b0, "R7 unexpected delivery", od[k], 0);
            end
         end
         if (stb[k] && pstb[k])
            chk(ld[k] == pld[k], "R3 link_data hold", ld[k], pld[k]);
         if (ack[k] && !pack[k])
            chk(stb[k], "R4 ack rise with strobe", stb[k], 1);
         if (!ack[k] && pack[k])
            chk(!stb[k], "R4 ack fall with strobe low", stb[k], 0);
         if (pstb[k] && pack[k])
            chk(!stb[k], "R5 strobe dropped", stb[k], 0);
         pstb[k] = stb[k];
         pack[k] = ack[k];
         pld[k]  = ld[k];
      end
   endtask

   task automatic step_model();
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            busy[k] = 0; pend[k] = 0; expv[k] = 0;
            order_q[k].delete();
         end else begin
            bit acc;
            acc = in_valid && (busy[k] == 0);
            expv[k]  = pend[k];
            expd[k]  = pdata[k];
            pend[k]  = acc;
            pdata[k] = in_data;
            if (acc) begin
               busy[k] = period[k] - 1;
               order_q[k].push_back(in_data);
               sent[k]++;
            end else if (busy[k] > 0) begin
               busy[k]--;
            end
         end
      end
   endtask

   task automatic cycle(input bit v, input logic [W-1:0] d, input bit r);
      @(negedge clk);
      compare_all();
      rst_n    = r;
      in_valid = v;
      in_data  = d;
      step_model();
   endtask

   logic [W-1:0] lf = 16'hACE1;
   function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   initial begin
      for (int k = 0; k < 2; k++) begin
         busy[k] = 0; pend[k] = 0; expv[k] = 0; sent[k] = 0; got[k] = 0;
         pstb[k] = 0; pack[k] = 0; pld[k] = '0;
      end
      // Reset phase.
      for (int i = 0; i < 3; i++) cycle(1'b1, 16'h1234, 1'b0);
      cycle(1'b0, 16'h0, 1'b1);
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         chk(stb[k] == 0 && ack[k] == 0, "R1 link low after reset", {stb[k], ack[k]}, 0);
         chk(ov[k] == 0, "R1 out_valid low after reset", ov[k], 0);
         chk(rdy[k] == 1, "R1 in_ready high after reset", rdy[k], 1);
      end
      // Full-rate stream with in_data changing every cycle (R3, R8).
      for (int i = 0; i < 60; i++) begin
         if (i == 8) begin window[0] = 0; window[1] = 0; end
         lf = nxt(lf);
         cycle(1'b1, lf, 1'b1);
         if (i == 47) begin
            chk(window[0] == 20, "R8 rate fast variant", window[0], 20);
            chk(window[1] == 10, "R8 rate registered variant", window[1], 10);
         end
      end
      // Sparse random offers.
      for (int i = 0; i < 300; i++) begin
         lf = nxt(lf);
         cycle(lf[3] & lf[7], lf ^ 16'h5A5A, 1'b1);
      end
      for (int i = 0; i < 8; i++) cycle(1'b0, 16'h0, 1'b1);
      // Reset one cycle after a word is taken (R9).
      cycle(1'b1, 16'hBEEF, 1'b1);
      cycle(1'b0, 16'h0, 1'b0);
      @(negedge clk);
      for (int k = 0; k < 2; k++)
         chk(stb[k] == 0 && ack[k] == 0, "R9 link cleared by reset", {stb[k], ack[k]}, 0);
      cycle(1'b0, 16'h0, 1'b0);
      for (int i = 0; i < 6; i++) begin
         cycle(1'b0, 16'h0, 1'b1);
         for (int k = 0; k < 2; k++)
            chk(ov[k] == 0, "R9 discarded word not delivered", ov[k], 0);
      end
      // Short stream after reset, then drain.
      for (int i = 0; i < 12; i++) cycle(1'b1, 16'h0100 + 16'(i), 1'b1);
      for (int i = 0; i < 10; i++) cycle(1'b0, 16'h0, 1'b1);
      for (int k = 0; k < 2; k++)
         chk(order_q[k].size() == 0, "R6 every word delivered once",
             order_q[k].size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule